// File: doc/BRIEF.md
# Branch Resolution and Fetch Redirect

This block owns the fetch address of a five-stage pipeline and decides, for every cycle, whether the instruction being fetched may enter the fetch/decode register. The decode stage reports that it holds a branch. The stage that settles the branch condition reports the outcome and the target, which decode has already computed. From these the block chooses one of three outcomes: fetch carries on in sequence, fetch waits, or fetch is sent to the target while wrong-path instructions are turned into bubbles.

Two parameters set the behaviour. `POLICY` picks how the branch shadow is handled. The stall policy inserts bubbles until the outcome is known. The predict-not-taken policy keeps fetching in sequence and kills the wrong-path work only on a taken branch. The delay-slot policy always keeps the one instruction that follows a branch. `LATE_RESOLVE` selects where the outcome arrives: at the end of decode (0, one slot of shadow) or at the end of execute (1, two slots). A hold input from the load-use detector freezes the fetch address and the block's own state.

Top module: `brf_fetch_redirect`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pc_o` equals `RESET_PC`, `fetch_valid_o` is 1, and both flush outputs are 0 when no input is active.
- R2: When no hold, stall or taken resolution is present, `fetch_valid_o` is 1 and `pc_o` advances by 4 on the next clock edge.
- R3: While `hold_i` is 1, `pc_o` keeps its value, `fetch_valid_o` and both flush outputs are 0, and branch and resolution inputs are ignored. The stall wait state also keeps its value through the hold.
- R4: A resolution with `res_valid_i`=1 and `res_taken_i`=1, outside hold, loads `res_target_i` into `pc_o` on the next edge under every policy.
- R5: Stall policy, early resolution: a cycle with `dec_branch_i`=1 gives one bubble (`fetch_valid_o`=0) and does not advance `pc_o` unless the branch is taken.
- R6: Stall policy, late resolution: `dec_branch_i`=1 gives a bubble in that cycle and in the following cycle, when the outcome arrives. `pc_o` is held through both cycles, then becomes the target if the branch is taken or stays put if it is not.
- R7: Predict-not-taken policy: a not-taken resolution, or a branch in decode, causes no bubble and no flush.
- R8: Predict-not-taken policy, taken: with early resolution only `flush_if_o` is 1 (and `fetch_valid_o` is 0). With late resolution both `flush_if_o` and `flush_id_o` are 1.
- R9: Delay-slot policy, taken: with early resolution no flush is raised and the fetch stays valid. With late resolution only `flush_if_o` is 1 and the decode instruction is kept.
- R10: `flush_id_o` is never 1 in an early-resolution configuration, and it is never 1 without `flush_if_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_i | input | 1 | Load-use freeze of fetch address and fetch/decode register |
| dec_branch_i | input | 1 | Decode stage holds a valid branch |
| res_valid_i | input | 1 | Branch outcome is available this cycle |
| res_taken_i | input | 1 | Branch outcome: 1 taken |
| res_target_i | input | XLEN | Branch target computed in decode |
| pc_o | output | XLEN | Address being fetched this cycle |
| fetch_valid_o | output | 1 | Fetched instruction may enter fetch/decode as valid |
| flush_if_o | output | 1 | Kill the instruction fetched this cycle |
| flush_id_o | output | 1 | Kill the instruction now in decode |

## Verification
A wrong wait flag in the late stall configuration shows up within one cycle: the second bubble goes missing, or a stray bubble appears and stops `pc_o` from advancing. A wrong next-address selection shows on `pc_o` at the very next edge, as a missed redirect, a double step or a step during hold. Flush errors show on the same cycle as the resolution, because the flush outputs and `fetch_valid_o` depend combinationally on the resolution inputs.

// File: rtl/brf_pkg.sv
package brf_pkg;
   typedef enum logic [1:0] {
      POL_STALL      = 2'd0,
      POL_PREDICT_NT = 2'd1,
      POL_DELAY_SLOT = 2'd2
   } brf_policy_e;

   localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/brf_policy_ctrl.sv
module brf_policy_ctrl
   import brf_pkg::*;
#(
   parameter brf_policy_e POLICY       = POL_STALL,
   parameter bit          LATE_RESOLVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic dec_branch_i,
   input  logic res_valid_i,
   input  logic res_taken_i,
   output logic redirect_o,
   output logic stall_o,
   output logic flush_if_o,
   output logic flush_id_o
);
   localparam bit IS_STALL = (POLICY == POL_STALL);

   if (POLICY != POL_STALL && POLICY != POL_PREDICT_NT && POLICY != POL_DELAY_SLOT) begin : g_bad_policy
      $error("brf_policy_ctrl: unsupported POLICY");
   end

   assign redirect_o = !hold_i && res_valid_i && res_taken_i;

   if (IS_STALL && LATE_RESOLVE) begin : g_stall_late
      logic wait_q;
      always_ff @(posedge clk) begin
         if (!rst_n)       wait_q <= 1'b0;
         else if (!hold_i) wait_q <= dec_branch_i;
      end
      assign stall_o    = !hold_i && (dec_branch_i || wait_q);
      assign flush_if_o = 1'b0;
      assign flush_id_o = 1'b0;

      // R6: a branch seen in decode keeps fetch stalled on the following cycle too
      p_second_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_branch_i && !hold_i) |=> (stall_o || hold_i));
   end else if (IS_STALL) begin : g_stall_early
      assign stall_o    = !hold_i && dec_branch_i;
      assign flush_if_o = 1'b0;
      assign flush_id_o = 1'b0;
   end else if (POLICY == POL_PREDICT_NT) begin : g_pnt
      assign stall_o    = 1'b0;
      assign flush_if_o = redirect_o;
      assign flush_id_o = LATE_RESOLVE ? redirect_o : 1'b0;
   end else begin : g_dslot
      assign stall_o    = 1'b0;
      assign flush_if_o = LATE_RESOLVE ? redirect_o : 1'b0;
      assign flush_id_o = 1'b0;
   end
endmodule

// File: rtl/brf_pc_reg.sv
module brf_pc_reg #(
   parameter int unsigned      XLEN     = 32,
   parameter logic [XLEN-1:0]  RESET_PC = '0,
   parameter int unsigned      STEP     = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold_i,
   input  logic            stall_i,
   input  logic            redirect_i,
   input  logic [XLEN-1:0] target_i,
   output logic [XLEN-1:0] pc_o
);
   localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

   if (STEP == 0 || (RESET_PC % STEP) != 0) begin : g_bad_align
      $error("brf_pc_reg: RESET_PC must be a nonzero-step multiple");
   end

   logic [XLEN-1:0] pc_q, pc_d;

   always_comb begin
      if (hold_i)          pc_d = pc_q;
      else if (redirect_i) pc_d = target_i;
      else if (stall_i)    pc_d = pc_q;
      else                 pc_d = pc_q + STEP_V;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= RESET_PC;
      else        pc_q <= pc_d;
   end

   assign pc_o = pc_q;

   // R4: a redirect lands on the supplied target one edge later
   p_redirect_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_i |=> (pc_o == $past(target_i)));
endmodule

// File: rtl/brf_fetch_redirect.sv
module brf_fetch_redirect
   import brf_pkg::*;
#(
   parameter int unsigned      XLEN         = 32,
   parameter logic [XLEN-1:0]  RESET_PC     = '0,
   parameter brf_policy_e      POLICY       = POL_STALL,
   parameter bit               LATE_RESOLVE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold_i,
   input  logic            dec_branch_i,
   input  logic            res_valid_i,
   input  logic            res_taken_i,
   input  logic [XLEN-1:0] res_target_i,
   output logic [XLEN-1:0] pc_o,
   output logic            fetch_valid_o,
   output logic            flush_if_o,
   output logic            flush_id_o
);
   if (XLEN < 8) begin : g_bad_xlen
      $error("brf_fetch_redirect: XLEN too small");
   end

   logic redirect, stall;

   brf_policy_ctrl #(
      .POLICY      (POLICY),
      .LATE_RESOLVE(LATE_RESOLVE)
   ) u_policy (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_i      (hold_i),
      .dec_branch_i(dec_branch_i),
      .res_valid_i (res_valid_i),
      .res_taken_i (res_taken_i),
      .redirect_o  (redirect),
      .stall_o     (stall),
      .flush_if_o  (flush_if_o),
      .flush_id_o  (flush_id_o)
   );

   brf_pc_reg #(
      .XLEN    (XLEN),
      .RESET_PC(RESET_PC),
      .STEP    (INSN_BYTES)
   ) u_pc (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_i    (hold_i),
      .stall_i   (stall),
      .redirect_i(redirect),
      .target_i  (res_target_i),
      .pc_o      (pc_o)
   );

   assign fetch_valid_o = !hold_i && !stall && !flush_if_o;

   // R3: hold freezes the fetch address
   p_hold_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(pc_o));
   // R3: nothing valid or flushed while held
   p_hold_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |-> (!fetch_valid_o && !flush_if_o && !flush_id_o));
   // R2: a valid sequential fetch steps the address by one instruction
   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid_o && !(res_valid_i && res_taken_i)) |=> (pc_o == $past(pc_o) + XLEN'(INSN_BYTES)));
   // R10: decode is only ever flushed together with fetch
   p_id_with_if_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_id_o |-> flush_if_o);
   // R8: any flush belongs to a taken resolution
   p_flush_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_if_o |-> (res_valid_i && res_taken_i && !hold_i));
endmodule

// File: tb/brf_fetch_redirect_tb_top.sv
module brf_fetch_redirect_tb_top;
   import brf_pkg::*;

   localparam int NCFG = 6;
   localparam int XL   = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [NCFG-1:0] hold_v, dbr_v, rv_v, rt_v;
   logic [XL-1:0]   tgt_v [NCFG];
   logic [XL-1:0]   pc_w  [NCFG];
   logic [NCFG-1:0] fv_w, fif_w, fid_w;

   // cfg index = policy*2 + late (policy 0 stall, 1 predict-not-taken, 2 delay slot)
   for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
      brf_fetch_redirect #(
         .XLEN        (XL),
         .RESET_PC    ('0),
         .POLICY      (brf_policy_e'(gi / 2)),
         .LATE_RESOLVE(1'(gi % 2))
      ) dut_i (
         .clk          (clk),
         .rst_n        (rst_n),
         .hold_i       (hold_v[gi]),
         .dec_branch_i (dbr_v[gi]),
         .res_valid_i  (rv_v[gi]),
         .res_taken_i  (rt_v[gi]),
         .res_target_i (tgt_v[gi]),
         .pc_o         (pc_w[gi]),
         .fetch_valid_o(fv_w[gi]),
         .flush_if_o   (fif_w[gi]),
         .flush_id_o   (fid_w[gi])
      );
   end

   typedef struct packed {
      logic        first;
      logic [2:0]  cfg;
      logic        hold;
      logic        dbr;
      logic        rv;
      logic        rt;
      logic [15:0] tgt;
      logic        ev;
      logic        efi;
      logic        efd;
      logic [15:0] epc;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 46;
   localparam vec_t TBL [NV] = '{
      // stall, early (cfg0): R1 R2 R5 R4 R3
      '{1'b1,3'd0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,4'd1},
      '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0004,4'd2},
      '{1'b0,3'd0,1'b0,1'b1,1'b1,1'b1,16'h0040,1'b0,1'b0,1'b0,16'h0008,4'd5},
      '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0040,4'd4},
      '{1'b0,3'd0,1'b0,1'b1,1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0044,4'd5},
      '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0044,4'd5},
      '{1'b0,3'd0,1'b1,1'b0,1'b1,1'b1,16'h0080,1'b0,1'b0,1'b0,16'h0048,4'd3},
      '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0048,4'd3},
      // stall, late (cfg1): R6 R4 R3
      '{1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,4'd1},
      '{1'b0,3'd1,1'b0,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0004,4'd6},
      '{1'b0,3'd1,1'b0,1'b0,1'b1,1'b1,16'h0060,1'b0,1'b0,1'b0,16'h0004,4'd6},
      '{1'b0,3'd1,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0060,4'd4},
      '{1'b0,3'd1,1'b0,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0064,4'd6},
      '{1'b0,3'd1,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0064,4'd6},
      '{1'b0,3'd1,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0064,4'd6},
      '{1'b0,3'd1,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0068,4'd2},
      '{1'b0,3'd1,1'b0,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h006C,4'd6},
      '{1'b0,3'd1,1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h006C,4'd3},
      '{1'b0,3'd1,1'b0,1'b0,1'b1,1'b1,16'h0020,1'b0,1'b0,1'b0,16'h006C,4'd3},
      '{1'b0,3'd1,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0020,4'd4},
      // predict-not-taken, early (cfg2): R7 R8 R10
      '{1'b1,3'd2,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,4'd1},
      '{1'b0,3'd2,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0004,4'd2},
      '{1'b0,3'd2,1'b0,1'b1,1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0008,4'd7},
      '{1'b0,3'd2,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h000C,4'd7},
      '{1'b0,3'd2,1'b0,1'b1,1'b1,1'b1,16'h0100,1'b0,1'b1,1'b0,16'h0010,4'd8},
      '{1'b0,3'd2,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0100,4'd4},
      // predict-not-taken, late (cfg3): R7 R8
      '{1'b1,3'd3,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,4'd1},
      '{1'b0,3'd3,1'b0,1'b1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0004,4'd7},
      '{1'b0,3'd3,1'b0,1'b0,1'b1,1'b1,16'h0200,1'b0,1'b1,1'b1,16'h0008,4'd8},
      '{1'b0,3'd3,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0200,4'd4},
      '{1'b0,3'd3,1'b0,1'b1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0204,4'd7},
      '{1'b0,3'd3,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0208,4'd7},
      '{1'b0,3'd3,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h020C,4'd2},
      '{1'b0,3'd3,1'b1,1'b0,1'b1,1'b1,16'h0300,1'b0,1'b0,1'b0,16'h0210,4'd3},
      '{1'b0,3'd3,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0210,4'd3},
      // delay slot, early (cfg4): R9 R10
      '{1'b1,3'd4,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,4'd1},
      '{1'b0,3'd4,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0004,4'd2},
      '{1'b0,3'd4,1'b0,1'b1,1'b1,1'b1,16'h0300,1'b1,1'b0,1'b0,16'h0008,4'd9},
      '{1'b0,3'd4,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0300,4'd4},
      '{1'b0,3'd4,1'b0,1'b1,1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0304,4'd9},
      // delay slot, late (cfg5): R9
      '{1'b1,3'd5,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,4'd1},
      '{1'b0,3'd5,1'b0,1'b1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0004,4'd9},
      '{1'b0,3'd5,1'b0,1'b0,1'b1,1'b1,16'h0400,1'b0,1'b1,1'b0,16'h0008,4'd9},
      '{1'b0,3'd5,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0400,4'd4},
      '{1'b0,3'd5,1'b0,1'b1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0404,4'd9},
      '{1'b0,3'd5,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0408,4'd9}
   };

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   task automatic clear_inputs();
      hold_v = '0; dbr_v = '0; rv_v = '0; rt_v = '0;
      for (int k = 0; k < NCFG; k++) tgt_v[k] = '0;
   endtask

   task automatic do_reset();
      clear_inputs();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic check_cfg(input int c, input logic ev, input logic efi, input logic efd,
                            input logic [XL-1:0] epc, input int req);
      n_checks++;
      if (fv_w[c] !== ev || fif_w[c] !== efi || fid_w[c] !== efd || pc_w[c] !== epc) begin
         n_fails++;
         $display("FAIL R%0d cfg%0d: got valid=%b fif=%b fid=%b pc=%h, expected valid=%b fif=%b fid=%b pc=%h",
                  req, c, fv_w[c], fif_w[c], fid_w[c], pc_w[c], ev, efi, efd, epc);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : main
      clear_inputs();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);

      // R1: outputs during reset, all configurations
      #1;
      for (int c = 0; c < NCFG; c++) check_cfg(c, 1'b1, 1'b0, 1'b0, '0, 1);

      // vector table
      for (int i = 0; i < NV; i++) begin
         if (TBL[i].first) do_reset();
         else begin
            @(negedge clk);
            clear_inputs();
         end
         hold_v[TBL[i].cfg] = TBL[i].hold;
         dbr_v[TBL[i].cfg]  = TBL[i].dbr;
         rv_v[TBL[i].cfg]   = TBL[i].rv;
         rt_v[TBL[i].cfg]   = TBL[i].rt;
         tgt_v[TBL[i].cfg]  = {16'h0, TBL[i].tgt};
         #1;
         check_cfg(int'(TBL[i].cfg), TBL[i].ev, TBL[i].efi, TBL[i].efd, {16'h0, TBL[i].epc}, int'(TBL[i].req));
      end
      @(negedge clk);
      clear_inputs();

      // R3: a long hold with taken resolutions applied to every configuration
      do_reset();
      #1;
      @(negedge clk);
      hold_v = '1; rv_v = '1; rt_v = '1;
      for (int k = 0; k < NCFG; k++) tgt_v[k] = 32'h0000_0800;
      for (int cyc = 0; cyc < 3; cyc++) begin
         #1;
         for (int c = 0; c < NCFG; c++) check_cfg(c, 1'b0, 1'b0, 1'b0, 32'h4, 3);
         @(negedge clk);
      end
      clear_inputs();
      #1;
      // R2: sequential fetch resumes from the frozen address
      for (int c = 0; c < NCFG; c++) check_cfg(c, 1'b1, 1'b0, 1'b0, 32'h4, 2);

      // R10: taken resolution in every early configuration never flushes decode
      @(negedge clk);
      for (int c = 0; c < NCFG; c += 2) begin
         dbr_v[c] = 1'b1; rv_v[c] = 1'b1; rt_v[c] = 1'b1; tgt_v[c] = 32'h0000_0900;
      end
      #1;
      for (int c = 0; c < NCFG; c += 2) begin
         n_checks++;
         if (fid_w[c] !== 1'b0) begin
            n_fails++;
            $display("FAIL R10 cfg%0d: got flush_id=%b, expected 0", c, fid_w[c]);
         end
      end
      @(negedge clk);
      clear_inputs();
      #1;
      // R4: every early configuration landed on the target
      for (int c = 0; c < NCFG; c += 2) check_cfg(c, 1'b1, 1'b0, 1'b0, 32'h0000_0900, 4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule